// File: doc/BRIEF.md
# Packed Register-Access Command Engine

This block sits on the controller side of a host mailbox and carries out batched accesses to a local byte-wide register file. The host side fills a 16-byte write buffer and presents a command id and a byte size. It then pulses a request. The engine captures the command and checks the whole batch before it touches anything. It then walks the packed entries one per cycle: it writes a register, reads a register, or merges a new value into a register under a mask.

Read results go into a persistent 16-byte read buffer. Each result lands at the byte lane that held the data field of its entry, so the host can take the result of entry n from the same position it used to send that entry. When the batch finishes, or is rejected, the engine raises a one-cycle done pulse and an error flag that says which of the two happened.

The register file holds REG_DEPTH bytes and is addressed by 16-bit addresses. A whole batch is rejected with no access at all if any entry names an address at or above REG_DEPTH.

Top module: `regcmd_engine`

## Requirements
- R1: The command id picks the operation: 0 writes, 1 reads, 2 does a masked read-modify-write. Any other id is rejected with the error flag set, and no register or read-buffer byte changes.
- R2: A write or read entry n takes 3 bytes starting at buffer byte 3n: address low byte, then address high byte, then the data byte. The data byte is ignored for reads.
- R3: A read-modify-write entry n takes 4 bytes starting at buffer byte 4n: address low, address high, new value, mask. The register becomes (old AND NOT mask) OR (new AND mask).
- R4: The size is the entry count times 3 (write, read) or times 4 (read-modify-write). A size that is not an exact multiple of the entry length is rejected with no access.
- R5: A batch holds 1 to 5 entries and must fit within the 16-byte buffer, so a read-modify-write batch holds at most 4 entries. A count of zero or one outside these limits is rejected with no access.
- R6: If any entry of a batch has an address at or above REG_DEPTH, with the high byte counted, the whole batch is rejected and none of its entries is carried out.
- R7: For a read, the byte read for entry n is placed at read-buffer byte 2+3n. Read-buffer bytes that a command does not write keep their earlier values.
- R8: Entries run strictly in buffer order, so a later entry sees the effect of an earlier one on the same address.
- R9: A request is sampled on a rising edge. An accepted batch of N entries raises busy and then gives a single-cycle done pulse with err low, N edges after the sampling edge. A rejected batch gives done with err high on the sampling edge itself, and busy does not rise. err holds its value until the next done.
- R10: A request is ignored while busy or done is high.
- R11: After reset, busy, done and err are low, the read buffer is all zero and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request pulse; command fields are sampled with it |
| cmd_id | input | 4 | Operation selector |
| cmd_size | input | 8 | Batch size in bytes |
| wbuf | input | 8*BUF_BYTES | Packed entry buffer, byte k at bits 8k+7..8k |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last completed request |
| rbuf | output | 8*BUF_BYTES | Read-result buffer, byte k at bits 8k+7..8k |

## Verification
The bench builds the engine with REG_DEPTH set to 24, which is not a power of two, and leaves the 5-entry limit and the 16-byte buffer at their defaults. With a small, odd depth, random addresses often collide within a batch and across batches, which exercises in-order merging. It also puts the range boundary between 23 and 24 inside the decoded index width, so an out-of-range address cannot hide behind truncation. The 16-byte buffer puts the 4-entry read-modify-write limit and the 5-entry read limit (bytes 2 to 14) within reach of directed cases.

// File: rtl/regcmd_pkg.sv
// Shared constants and helpers for the packed register-access engine.
// Assumes two address bytes per entry and a 4-bit command id.
package regcmd_pkg;
    localparam int ID_W   = 4;
    localparam int SIZE_W = 8;

    localparam logic [ID_W-1:0] OP_WRITE = 4'd0;
    localparam logic [ID_W-1:0] OP_READ  = 4'd1;
    localparam logic [ID_W-1:0] OP_RMW   = 4'd2;

    // Bytes taken by one entry of the given operation
    function automatic int unsigned entry_bytes(input logic [ID_W-1:0] id);
        return (id == OP_RMW) ? 4 : 3;
    endfunction
endpackage

// File: rtl/regcmd_check.sv
// Validates a request as it is presented: known id, exact size,
// entry count within limits and buffer, and every address in range.
// Assumes the buffer bytes are stable in the request cycle.
module regcmd_check
    import regcmd_pkg::*;
#(
    parameter int REG_DEPTH   = 64,
    parameter int BUF_BYTES   = 16,
    parameter int MAX_ENTRIES = 5,
    parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic [ID_W-1:0]        id,
    input  logic [SIZE_W-1:0]      size,
    input  logic [BUF_BYTES*8-1:0] buf_i,
    output logic                   ok,
    output logic [CNT_W-1:0]       count
);
    int unsigned len;
    int unsigned cnt;
    int unsigned base;
    int unsigned addr;

    // Decide acceptance and entry count for the presented command
    always_comb begin
        len  = entry_bytes(id);
        cnt  = 32'(size) / len;
        base = 0;
        addr = 0;
        ok   = (id <= OP_RMW) && ((32'(size) % len) == 0) && (cnt >= 1)
               && (cnt <= MAX_ENTRIES) && (32'(size) <= BUF_BYTES);
        for (int n = 0; n < MAX_ENTRIES; n++) begin
            base = 32'(n) * len;
            if ((32'(n) < cnt) && (base + 1 < BUF_BYTES)) begin
                addr = {16'h0, buf_i[(base+1)*8 +: 8], buf_i[base*8 +: 8]};
                if (addr >= REG_DEPTH) ok = 1'b0;
            end
        end
        count = ok ? CNT_W'(cnt) : '0;
    end
endmodule

// File: rtl/regcmd_entry.sv
// Picks entry idx out of a captured buffer: address, value, mask and the
// byte lane for a read result. Writes get an all-ones mask so that one
// merge path serves both writes and read-modify-writes.
module regcmd_entry #(
    parameter int BUF_BYTES = 16,
    parameter int CNT_W     = 3
) (
    input  logic [BUF_BYTES*8-1:0] buf_i,
    input  logic                   rmw,
    input  logic [CNT_W-1:0]       idx,
    output logic [15:0]            addr,
    output logic [7:0]             val,
    output logic [7:0]             mask,
    output logic [7:0]             pos
);
    int unsigned base;

    // Byte at position p, zero past the end of the buffer
    function automatic logic [7:0] byte_at(input logic [BUF_BYTES*8-1:0] b,
                                           input int unsigned p);
        return (p < BUF_BYTES) ? b[p*8 +: 8] : 8'h00;
    endfunction

    // Slice the fields of the selected entry
    always_comb begin
        base = rmw ? 32'(idx) * 4 : 32'(idx) * 3;
        addr = {byte_at(buf_i, base + 1), byte_at(buf_i, base)};
        val  = byte_at(buf_i, base + 2);
        mask = rmw ? byte_at(buf_i, base + 3) : 8'hFF;
        pos  = 8'(32'(idx) * 3 + 2);
    end
endmodule

// File: rtl/regcmd_regfile.sv
// Byte-wide register file with one combinational read and one write port.
// Assumes the caller writes only in-range addresses; out-of-range reads give 0.
module regcmd_regfile #(
    parameter int REG_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    logic [7:0] mem [REG_DEPTH];

    // Read the addressed byte
    always_comb rdata = (32'(addr) < REG_DEPTH) ? mem[32'(addr)] : 8'h00;

    // Clear on reset, otherwise store on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && (32'(addr) < REG_DEPTH)) begin
            mem[32'(addr)] <= wdata;
        end
    end

    a_r6_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(addr) < REG_DEPTH));
endmodule

// File: rtl/regcmd_engine.sv
// Command engine: captures a request, rejects invalid batches at once,
// otherwise executes one entry per cycle in buffer order and pulses done.
// Assumes req is sampled only while idle and done is low.
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter int REG_DEPTH   = 64,
    parameter int BUF_BYTES   = 16,
    parameter int MAX_ENTRIES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [ID_W-1:0]        cmd_id,
    input  logic [SIZE_W-1:0]      cmd_size,
    input  logic [BUF_BYTES*8-1:0] wbuf,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [BUF_BYTES*8-1:0] rbuf
);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

    logic                   busy_q, done_q, err_q;
    logic [ID_W-1:0]        cmd_q;
    logic [BUF_BYTES*8-1:0] buf_q, rbuf_q;
    logic [CNT_W-1:0]       count_q, idx_q;
    logic                   chk_ok;
    logic [CNT_W-1:0]       chk_count;
    logic [15:0]            e_addr;
    logic [7:0]             e_val, e_mask, e_pos;
    logic [7:0]             rd_data, wr_data;
    logic                   wr_en, accept, last;

    regcmd_check #(
        .REG_DEPTH(REG_DEPTH), .BUF_BYTES(BUF_BYTES),
        .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)
    ) check_i (
        .id(cmd_id), .size(cmd_size), .buf_i(wbuf),
        .ok(chk_ok), .count(chk_count)
    );

    regcmd_entry #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) entry_i (
        .buf_i(buf_q), .rmw(cmd_q == OP_RMW), .idx(idx_q),
        .addr(e_addr), .val(e_val), .mask(e_mask), .pos(e_pos)
    );

    regcmd_regfile #(.REG_DEPTH(REG_DEPTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(e_addr),
        .wdata(wr_data), .rdata(rd_data)
    );

    // Request acceptance, merge value and last-entry detection
    always_comb begin
        accept  = req && !busy_q && !done_q;
        wr_en   = busy_q && (cmd_q != OP_READ);
        wr_data = (rd_data & ~e_mask) | (e_val & e_mask);
        last    = (idx_q + CNT_W'(1)) == count_q;
    end

    // Sequencing, result capture and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            cmd_q   <= '0;
            buf_q   <= '0;
            rbuf_q  <= '0;
            count_q <= '0;
            idx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cmd_q   <= cmd_id;
                buf_q   <= wbuf;
                idx_q   <= '0;
                count_q <= chk_count;
                if (chk_ok) begin
                    busy_q <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                end
            end else if (busy_q) begin
                if ((cmd_q == OP_READ) && (32'(e_pos) < BUF_BYTES))
                    rbuf_q[32'(e_pos)*8 +: 8] <= rd_data;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= 1'b0;
                end else begin
                    idx_q <= idx_q + CNT_W'(1);
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign err  = err_q;
    assign rbuf = rbuf_q;

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (done_q && !err_q));
    a_r6_reject_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && err_q) |-> (!busy_q && !$past(busy_q)));
    a_r10_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(buf_q) && $stable(cmd_q)));
endmodule

// File: tb/regcmd_engine_tb_top.sv
module regcmd_engine_tb_top;
    localparam int DEPTH = 24;
    localparam int BUFB  = 16;
    localparam int MAXE  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [3:0]       cmd_id = '0;
    logic [7:0]       cmd_size = '0;
    logic [BUFB*8-1:0] wbuf = '0;
    logic             busy, done, err;
    logic [BUFB*8-1:0] rbuf;

    int checks = 0;
    int errors = 0;
    logic [7:0]        m_regs [DEPTH];
    logic [BUFB*8-1:0] m_rbuf;

    always #5 clk = ~clk;

    regcmd_engine #(.REG_DEPTH(DEPTH), .BUF_BYTES(BUFB), .MAX_ENTRIES(MAXE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .cmd_id(cmd_id), .cmd_size(cmd_size),
        .wbuf(wbuf), .busy(busy), .done(done), .err(err), .rbuf(rbuf)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [BUFB*8-1:0] act, input logic [BUFB*8-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model of one command; returns expected error and entry count
    task automatic model(input logic [3:0] id, input logic [7:0] sz,
                         input logic [BUFB*8-1:0] b, output bit bad, output int n);
        int len;
        int a;
        len = (id == 4'd2) ? 4 : 3;
        n   = int'(sz) / len;
        bad = (id > 4'd2) || (int'(sz) % len != 0) || (n == 0) || (n > MAXE) || (int'(sz) > BUFB);
        if (!bad)
            for (int k = 0; k < n; k++) begin
                a = int'({b[(k*len+1)*8 +: 8], b[k*len*8 +: 8]});
                if (a >= DEPTH) bad = 1'b1;
            end
        if (!bad)
            for (int k = 0; k < n; k++) begin
                a = int'({b[(k*len+1)*8 +: 8], b[k*len*8 +: 8]});
                if (id == 4'd0) m_regs[a] = b[(k*3+2)*8 +: 8];
                else if (id == 4'd1) m_rbuf[(k*3+2)*8 +: 8] = m_regs[a];
                else m_regs[a] = (m_regs[a] & ~b[(k*4+3)*8 +: 8]) | (b[(k*4+2)*8 +: 8] & b[(k*4+3)*8 +: 8]);
            end
    endtask

    // Issue one command, then check completion timing (R9), error and read buffer
    task automatic run_cmd(input logic [3:0] id, input logic [7:0] sz,
                           input logic [BUFB*8-1:0] b, input string tag);
        bit bad;
        int n;
        int cyc;
        model(id, sz, b, bad, n);
        @(negedge clk);
        req = 1'b1; cmd_id = id; cmd_size = sz; wbuf = b;
        @(negedge clk);
        req = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin @(negedge clk); cyc++; end
        check(cyc == (bad ? 0 : n), {"R9 done timing ", tag}, 128'(cyc), 128'(bad ? 0 : n));
        check(err == bad, {tag, " err"}, 128'(err), 128'(bad));
        check(rbuf == m_rbuf, {tag, " rbuf"}, rbuf, m_rbuf);
        @(negedge clk);
    endtask

    function automatic logic [BUFB*8-1:0] put(input logic [BUFB*8-1:0] b, input int p,
                                              input logic [7:0] v);
        logic [BUFB*8-1:0] r;
        r = b;
        if (p < BUFB) r[p*8 +: 8] = v;
        return r;
    endfunction

    // Read every register back through read commands (R7 lanes, R11 after reset)
    task automatic sweep(input string tag);
        logic [BUFB*8-1:0] b;
        for (int base = 0; base < DEPTH; base += 5) begin
            b = '0;
            for (int k = 0; k < 5; k++) begin
                b = put(b, k*3, 8'((base + k < DEPTH) ? base + k : DEPTH - 1));
                b = put(b, k*3 + 2, 8'hEE);
            end
            run_cmd(4'd1, 8'd15, b, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [BUFB*8-1:0] b;
        logic [3:0] id;
        logic [7:0] sz;
        int n;
        int len;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_regs[i] = 8'h00;
        m_rbuf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !err, "R11 flags after reset", 128'({busy, done, err}), 128'(0));
        check(rbuf == '0, "R11 rbuf after reset", rbuf, '0);
        sweep("R11 regs zero");

        // R2: five writes, then R7 readback
        b = '0;
        for (int k = 0; k < 5; k++) begin
            b = put(b, k*3, 8'(k*4 + 1));
            b = put(b, k*3 + 2, 8'(8'h30 + k));
        end
        run_cmd(4'd0, 8'd15, b, "R2 write five");
        run_cmd(4'd1, 8'd15, b, "R7 read five");
        // R7: single read leaves bytes 5..14 unchanged
        b = '0; b = put(b, 0, 8'd9); b = put(b, 2, 8'h55);
        run_cmd(4'd1, 8'd3, b, "R7 partial read");

        // R3: masked merge, exact value
        b = '0; b = put(b, 0, 8'd3); b = put(b, 2, 8'hA5);
        run_cmd(4'd0, 8'd3, b, "R2 write A5");
        b = '0; b = put(b, 0, 8'd3); b = put(b, 2, 8'h5A); b = put(b, 3, 8'h0F);
        run_cmd(4'd2, 8'd4, b, "R3 rmw");
        b = '0; b = put(b, 0, 8'd3);
        run_cmd(4'd1, 8'd3, b, "R3 readback");
        check(rbuf[2*8 +: 8] == 8'hAA, "R3 merged value", 128'(rbuf[2*8 +: 8]), 128'(8'hAA));

        // R8: same address twice, in order
        b = '0; b = put(b, 0, 8'd7); b = put(b, 2, 8'h11); b = put(b, 3, 8'd7); b = put(b, 5, 8'h22);
        run_cmd(4'd0, 8'd6, b, "R8 write twice");
        b = '0; b = put(b, 0, 8'd7); b = put(b, 2, 8'hF0); b = put(b, 3, 8'hF0);
        b = put(b, 4, 8'd7); b = put(b, 6, 8'h03); b = put(b, 7, 8'h0F);
        run_cmd(4'd2, 8'd8, b, "R8 rmw chain");
        b = '0; b = put(b, 0, 8'd7);
        run_cmd(4'd1, 8'd3, b, "R8 readback");
        check(rbuf[2*8 +: 8] == 8'hF3, "R8 chained value", 128'(rbuf[2*8 +: 8]), 128'(8'hF3));

        // R4, R5, R1 rejects
        b = '0; b = put(b, 0, 8'd1); b = put(b, 2, 8'hC3);
        run_cmd(4'd0, 8'd7, b, "R4 size not multiple");
        run_cmd(4'd0, 8'd0, b, "R5 zero count");
        run_cmd(4'd1, 8'd18, b, "R5 six entries");
        run_cmd(4'd2, 8'd20, b, "R5 rmw five entries");
        run_cmd(4'd3, 8'd3, b, "R1 unknown id");
        run_cmd(4'd15, 8'd3, b, "R1 id 15");
        b = '0;
        for (int k = 0; k < 4; k++) begin
            b = put(b, k*4, 8'(k + 12)); b = put(b, k*4 + 2, 8'h99); b = put(b, k*4 + 3, 8'h3C);
        end
        run_cmd(4'd2, 8'd16, b, "R5 rmw four entries");

        // R6: one bad address rejects the whole batch
        b = '0;
        b = put(b, 0, 8'd0); b = put(b, 2, 8'h77);
        b = put(b, 3, 8'd1); b = put(b, 5, 8'h77);
        b = put(b, 6, 8'(DEPTH)); b = put(b, 8, 8'h77);
        run_cmd(4'd0, 8'd9, b, "R6 addr at depth");
        b = put(b, 6, 8'd2); b = put(b, 7, 8'h01);
        run_cmd(4'd0, 8'd9, b, "R6 high byte set");
        b = put(b, 6, 8'(DEPTH - 1)); b = put(b, 7, 8'h00);
        run_cmd(4'd0, 8'd9, b, "R6 last address ok");
        sweep("R6 state after rejects");

        // R10: a request held while busy is ignored
        b = '0;
        for (int k = 0; k < 5; k++) begin
            b = put(b, k*3, 8'(k)); b = put(b, k*3 + 2, 8'(8'h60 + k));
        end
        model(4'd0, 8'd15, b, len[0], n);
        @(negedge clk);
        req = 1'b1; cmd_id = 4'd0; cmd_size = 8'd15; wbuf = b;
        @(negedge clk);
        wbuf = '0; wbuf[7:0] = 8'd20; wbuf[23:16] = 8'h77; cmd_size = 8'd3;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy during batch", 128'(busy), 128'(1));
        @(negedge clk);
        req = 1'b0;
        n = 2;
        while (!done && n < 40) begin @(negedge clk); n++; end
        check(n == 5, "R10 done timing unchanged", 128'(n), 128'(5));
        @(negedge clk);
        sweep("R10 ignored request");

        // Random batches
        for (int t = 0; t < 400; t++) begin
            id = ($urandom % 10 == 0) ? 4'(3 + $urandom % 13) : 4'($urandom % 3);
            len = (id == 4'd2) ? 4 : 3;
            n = 1 + int'($urandom % ((id == 4'd2) ? 4 : 5));
            b = '0;
            for (int k = 0; k < n; k++) begin
                if ($urandom % 12 == 0) begin
                    b = put(b, k*len, 8'(DEPTH + $urandom % 8));
                    b = put(b, k*len + 1, 8'($urandom % 2));
                end else begin
                    b = put(b, k*len, 8'($urandom % DEPTH));
                end
                b = put(b, k*len + 2, 8'($urandom));
                if (len == 4) b = put(b, k*len + 3, 8'($urandom));
            end
            sz = ($urandom % 10 == 0) ? 8'($urandom % 21) : 8'(n * len);
            case (id)
                4'd0: run_cmd(id, sz, b, "R2 random write");
                4'd1: run_cmd(id, sz, b, "R7 random read");
                4'd2: run_cmd(id, sz, b, "R3 random rmw");
                default: run_cmd(id, sz, b, "R1 random bad id");
            endcase
            if (t % 80 == 79) sweep("R8 random state");
        end
        sweep("R8 final state");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule